// File: doc/BRIEF.md
# Power Fault Mode Controller

This block decides the operating mode of a metering chip when its main supply weakens. A comparator reports whether the fault-sense voltage is above the internal bias level. The block resynchronises that bit and filters it over a programmable number of cycles. From the filtered level, a firmware brownout-enable bit and two battery-adequacy flags, it picks one of four modes.

When power is lost it does not simply reset. With brownout supported and enough battery margin, it keeps the processor alive on the slow 32 kHz clock and turns the measurement front end off. With less margin it falls to sleep, where only timekeeping runs. Without support or without battery it holds the chip in reset.

Recovery always goes through a reset sequence of fixed length before normal operation resumes. A static strap input marks the fault-sense pin as tied to the supply rail. While the strap is set, fault detection is off.

Top module: `pfm_mode_ctrl`

## Requirements
- R1: The mode output encodes normal as 2'b00, brownout as 2'b01, sleep as 2'b10 and reset as 2'b11. The front-end enable is high only in normal, the slow-clock select is high only in brownout, and the reset request is high only in reset.
- R2: A comparator level change is held for `filt_cycles` consecutive cycles after a two-flop synchronizer (a value of 0 acts as 1). The resulting mode change appears at the (`filt_cycles`+3)th rising edge, counting the first edge that samples the new level as edge 1.
- R3: A comparator pulse shorter than `filt_cycles` cycles does not change the mode.
- R4: On a fault in normal mode with brownout enabled and the brownout battery flag high, the mode becomes brownout.
- R5: On a fault in normal mode with brownout enabled, the brownout battery flag low and the sleep battery flag high, the mode becomes sleep.
- R6: On a fault in normal mode with brownout disabled, or with both battery flags low, the mode becomes reset.
- R7: While the fault persists, a brownout battery flag that goes low moves brownout to sleep, or to reset if the sleep flag is also low. A sleep flag that goes low moves sleep to reset. Each of these moves takes effect on the next rising edge.
- R8: When the filtered comparator returns high in brownout or sleep, the mode goes to reset and never directly to normal. A recovery through reset holds reset for exactly `RST_CYCLES` cycles with power good, then goes to normal.
- R9: While the sense-tied strap is high, comparator faults are ignored and the mode stays normal.
- R10: During and right after asynchronous reset the mode is reset. After reset release, the mode becomes normal on the `RST_CYCLES`th rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_above_bias | input | 1 | Raw comparator: fault-sense voltage above bias |
| sense_tied | input | 1 | Static strap: fault-sense pin tied to supply, detection off |
| bo_enable | input | 1 | Firmware supports brownout |
| bat_bo_ok | input | 1 | Battery adequate for brownout |
| bat_sleep_ok | input | 1 | Battery adequate for sleep |
| filt_cycles | input | CNT_W | Required stable cycles before a level change is accepted |
| mode | output | 2 | Mode code |
| cpu_clk_slow | output | 1 | Select 32 kHz processor clock |
| afe_enable | output | 1 | Measurement front-end enable |
| reset_req | output | 1 | Chip reset request |

## Verification
The decision logic is driven by every combination that separates the three degraded paths: brownout with full margin, sleep with only sleep margin, and reset either with brownout disabled or with no margin. Battery flags are then withdrawn in the middle of a fault, which shows that the controller steps down brownout to sleep to reset rather than holding its first choice. A comparator glitch one cycle shorter than the filter window and an exact latency count on a held fault separate correct filtering from an off-by-one. Recovery from each degraded mode, and a long fault under the tied strap, show that normal is only ever reached through the full reset sequence.

// File: rtl/pfm_pkg.sv
package pfm_pkg;
  typedef enum logic [1:0] {
    PM_NORMAL = 2'b00,
    PM_BROWN  = 2'b01,
    PM_SLEEP  = 2'b10,
    PM_RESET  = 2'b11
  } pm_mode_e;
endpackage

// File: rtl/pfm_sync.sv
module pfm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] chain_q;

  // Reset to "power good" so a fresh reset does not look like a fault.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], d_async};
  end

  assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pfm_filter.sv
module pfm_filter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_in,
  input  logic [CNT_W-1:0] hold_cycles,
  output logic             lvl_out
);
  logic             lvl_q, lvl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] limit;

  assign limit = (hold_cycles == '0) ? '0 : hold_cycles - 1'b1;

  always_comb begin
    lvl_d = lvl_q;
    cnt_d = cnt_q;
    if (lvl_in == lvl_q) begin
      cnt_d = '0;
    end else if (cnt_q >= limit) begin
      lvl_d = lvl_in;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      cnt_q <= cnt_d;
    end
  end

  assign lvl_out = lvl_q;

  // R2: the filtered level only ever moves toward the synchronized input
  a_r2_follow_input: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl_q) |-> $past(lvl_in) == lvl_q);
  // R3: a level that just went back to agreeing never flips the output next
  a_r3_no_flip_on_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_in == lvl_q) |=> $stable(lvl_q));
endmodule

// File: rtl/pfm_fsm.sv
module pfm_fsm
  import pfm_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pwr_good,
  input  logic     bo_enable,
  input  logic     bat_bo_ok,
  input  logic     bat_sleep_ok,
  output pm_mode_e mode_q
);
  localparam int RCNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [RCNT_W-1:0] RCNT_LAST = RCNT_W'(RST_CYCLES - 1);

  pm_mode_e          state_q, state_d;
  logic [RCNT_W-1:0] rcnt_q, rcnt_d;
  logic              can_brown, can_sleep;

  assign can_brown = bo_enable & bat_bo_ok;
  assign can_sleep = bo_enable & bat_sleep_ok;

  always_comb begin
    state_d = state_q;
    rcnt_d  = '0;
    unique case (state_q)
      PM_NORMAL: begin
        if (!pwr_good) begin
          if (can_brown)      state_d = PM_BROWN;
          else if (can_sleep) state_d = PM_SLEEP;
          else                state_d = PM_RESET;
        end
      end
      PM_BROWN: begin
        if (pwr_good)        state_d = PM_RESET;
        else if (!can_brown) state_d = can_sleep ? PM_SLEEP : PM_RESET;
      end
      PM_SLEEP: begin
        if (pwr_good || !can_sleep) state_d = PM_RESET;
      end
      PM_RESET: begin
        if (pwr_good) begin
          if (rcnt_q == RCNT_LAST) state_d = PM_NORMAL;
          else                     rcnt_d  = rcnt_q + 1'b1;
        end
      end
      default: state_d = PM_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PM_RESET;
      rcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      rcnt_q  <= rcnt_d;
    end
  end

  assign mode_q = state_q;

  // R8: sleep never leads straight to normal
  a_r8_sleep_not_normal: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_SLEEP) |=> (state_q != PM_NORMAL));
  // R8/R10: normal is only entered from reset
  a_r8_normal_via_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_NORMAL && $past(state_q) != PM_NORMAL) |-> $past(state_q) == PM_RESET);
  // R4: brownout entered only with support and margin
  a_r4_brown_needs_margin: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_BROWN && $past(state_q) != PM_BROWN) |-> $past(bo_enable && bat_bo_ok));
  // R6: without brownout support a fault never keeps the processor running
  a_r6_no_support_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_NORMAL && !pwr_good && !bo_enable) |=> (state_q == PM_RESET));
endmodule

// File: rtl/pfm_mode_ctrl.sv
module pfm_mode_ctrl
  import pfm_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int RST_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_above_bias,
  input  logic             sense_tied,
  input  logic             bo_enable,
  input  logic             bat_bo_ok,
  input  logic             bat_sleep_ok,
  input  logic [CNT_W-1:0] filt_cycles,
  output logic [1:0]       mode,
  output logic             cpu_clk_slow,
  output logic             afe_enable,
  output logic             reset_req
);
  logic     cmp_sync, cmp_filt, pwr_good;
  pm_mode_e cur_mode;

  pfm_sync #(.STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (cmp_above_bias),
    .d_sync  (cmp_sync)
  );

  pfm_filter #(.CNT_W(CNT_W)) u_filter (
    .clk         (clk),
    .rst_n       (rst_n),
    .lvl_in      (cmp_sync),
    .hold_cycles (filt_cycles),
    .lvl_out     (cmp_filt)
  );

  // A tied sense pin disables detection: power is always considered good.
  assign pwr_good = cmp_filt | sense_tied;

  pfm_fsm #(.RST_CYCLES(RST_CYCLES)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_good     (pwr_good),
    .bo_enable    (bo_enable),
    .bat_bo_ok    (bat_bo_ok),
    .bat_sleep_ok (bat_sleep_ok),
    .mode_q       (cur_mode)
  );

  assign mode         = cur_mode;
  assign afe_enable   = (cur_mode == PM_NORMAL);
  assign cpu_clk_slow = (cur_mode == PM_BROWN);
  assign reset_req    = (cur_mode == PM_RESET);

  // R1: at most one control output active
  a_r1_onehot_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({afe_enable, cpu_clk_slow, reset_req}));
  // R9: tied sense pin keeps normal mode
  a_r9_tied_stays_normal: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_tied && mode == 2'b00) |=> (mode == 2'b00));
endmodule

// File: tb/tb_pfm_mode_ctrl.sv
module tb_pfm_mode_ctrl;
  localparam int CNT_W = 8;
  localparam int RSTC  = 6;
  localparam int FILT  = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic cmp, tied, bo_en, bbo, bsl;
  logic [CNT_W-1:0] filt;
  logic [1:0] mode;
  logic slow, afe, rreq;

  int checks = 0;
  int errors = 0;
  logic [1:0] exp_q[$];
  logic [1:0] last_mode;
  bit mon_on = 1'b0;

  always #5 clk = ~clk;

  pfm_mode_ctrl #(.CNT_W(CNT_W), .RST_CYCLES(RSTC)) dut (
    .clk(clk), .rst_n(rst_n), .cmp_above_bias(cmp), .sense_tied(tied),
    .bo_enable(bo_en), .bat_bo_ok(bbo), .bat_sleep_ok(bsl), .filt_cycles(filt),
    .mode(mode), .cpu_clk_slow(slow), .afe_enable(afe), .reset_req(rreq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic push(input logic [1:0] m);
    exp_q.push_back(m);
  endtask

  task automatic wait_mode(input logic [1:0] m, input string req);
    int n = 0;
    while (mode != m && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(mode == m, req, mode, m);
  endtask

  // Monitor: every mode change must match the next expected item; outputs per R1.
  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      if (mode != last_mode) begin
        if (exp_q.size() == 0) chk(1'b0, "R8 unexpected mode change", mode, last_mode);
        else begin
          logic [1:0] e;
          e = exp_q.pop_front();
          chk(mode == e, "R7 mode sequence", mode, e);
        end
        last_mode = mode;
      end
      chk(afe == (mode == 2'b00) && slow == (mode == 2'b01) && rreq == (mode == 2'b11),
          "R1 output decode", {afe, slow, rreq}, mode);
    end
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmp = 1'b1; tied = 1'b0; bo_en = 1'b0; bbo = 1'b0; bsl = 1'b0;
    filt = CNT_W'(FILT);
    edges(3);
    chk(mode == 2'b11 && rreq, "R10 mode in reset", mode, 3);
    rst_n = 1'b1;
    edges(RSTC - 1);
    chk(mode == 2'b11, "R10 still reset before count", mode, 3);
    edges(1);
    chk(mode == 2'b00 && afe, "R10 normal after RST_CYCLES", mode, 0);
    last_mode = mode;
    mon_on = 1'b1;

    // R3: glitch one cycle shorter than the filter window
    cmp = 1'b0; edges(FILT - 1); cmp = 1'b1;
    edges(12);
    chk(mode == 2'b00, "R3 short glitch ignored", mode, 0);

    // R2 + R4: exact latency into brownout
    bo_en = 1'b1; bbo = 1'b1; bsl = 1'b1;
    push(2'b01);
    cmp = 1'b0;
    edges(FILT + 2);
    chk(mode == 2'b00, "R2 not yet changed", mode, 0);
    edges(1);
    chk(mode == 2'b01 && slow && !afe, "R2 R4 brownout at edge N+3", mode, 1);

    // R7: brownout battery lost, sleep margin present -> sleep next edge
    push(2'b10);
    bbo = 1'b0;
    edges(1);
    chk(mode == 2'b10 && !slow && !afe && !rreq, "R7 brownout to sleep", mode, 2);

    // R8: recovery from sleep goes via reset
    push(2'b11); push(2'b00);
    cmp = 1'b1;
    wait_mode(2'b11, "R8 sleep recovers into reset");
    edges(RSTC - 1);
    chk(mode == 2'b11, "R8 reset held", mode, 3);
    edges(1);
    chk(mode == 2'b00, "R8 normal after reset sequence", mode, 0);

    // R5: sleep on fault with only sleep margin; then R7 sleep -> reset
    push(2'b10);
    cmp = 1'b0;
    wait_mode(2'b10, "R5 fault into sleep");
    push(2'b11);
    bsl = 1'b0;
    edges(1);
    chk(mode == 2'b11, "R7 sleep to reset", mode, 3);
    push(2'b00);
    edges(20);
    chk(mode == 2'b11, "R8 reset held during fault", mode, 3);
    cmp = 1'b1;
    wait_mode(2'b00, "R8 normal after fault clears");

    // R6: brownout disabled with full battery -> reset
    bo_en = 1'b0; bbo = 1'b1; bsl = 1'b1;
    push(2'b11);
    cmp = 1'b0;
    wait_mode(2'b11, "R6 no support gives reset");
    push(2'b00);
    cmp = 1'b1;
    wait_mode(2'b00, "R6 recovery");

    // R6: support but no margin -> reset
    bo_en = 1'b1; bbo = 1'b0; bsl = 1'b0;
    push(2'b11);
    cmp = 1'b0;
    wait_mode(2'b11, "R6 no margin gives reset");
    push(2'b00);
    cmp = 1'b1;
    wait_mode(2'b00, "R6 recovery 2");

    // R8: brownout recovery via reset; R7 brownout -> reset with no sleep margin
    bbo = 1'b1;
    push(2'b01);
    cmp = 1'b0;
    wait_mode(2'b01, "R4 brownout again");
    push(2'b11);
    bbo = 1'b0;
    edges(1);
    chk(mode == 2'b11, "R7 brownout to reset", mode, 3);
    push(2'b00);
    cmp = 1'b1;
    wait_mode(2'b00, "R8 brownout path recovery");
    bbo = 1'b1;
    push(2'b01);
    cmp = 1'b0;
    wait_mode(2'b01, "R4 brownout third");
    push(2'b11); push(2'b00);
    cmp = 1'b1;
    wait_mode(2'b11, "R8 brownout recovers into reset");
    wait_mode(2'b00, "R8 then normal");

    // R9: tied strap masks faults
    tied = 1'b1;
    cmp = 1'b0;
    edges(30);
    chk(mode == 2'b00 && afe, "R9 tied strap ignores fault", mode, 0);
    cmp = 1'b1;
    edges(10);
    tied = 1'b0;
    edges(10);
    chk(mode == 2'b00, "R9 normal after strap release", mode, 0);

    chk(exp_q.size() == 0, "R8 all expected modes seen", exp_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule